// File: doc/BRIEF.md
# DLL Bring-Up Sequencer

This block brings a delay-locked loop from an unknown state to a locked, running state before any sampling-phase search begins. A single start pulse launches a fixed chain of single-cycle register writes. The chain first keeps the clock from being gated. It then holds the loop in reset and power-down, loads a frequency-band code, releases the loop, and turns on its enable and output. After that the sequencer watches a lock flag and ends with either a completion pulse or a timeout pulse.

Two registers are held inside the block as flops and shown on output ports: a vendor control register and the DLL configuration register. The bus clock rate is given in kHz on an input port. The lock flag comes from the loop, which the bench replaces with a stub. The microsecond interval is a parameter, expressed in clock cycles, and so is the number of intervals allowed before timeout.

Top module: `dll_bringup_seq`

## Requirements
- R1: While reset is held, and on its release, the vendor register equals VSPEC_RST, the configuration register equals CFG_RST, and busy, done and lock_err are all 0.
- R2: On the first edge after start is accepted, bit 1 of the vendor register (clock gating permit) is cleared. No other bit of that register ever changes.
- R3: After acceptance, each later edge makes exactly one change to the configuration register, in this order: set bit 30 (reset), set bit 29 (power-down), load the band code, clear bit 30, clear bit 29, set bit 16 (enable), set bit 18 (output enable).
- R4: The band code goes into configuration bits 26:24. With rate f in kHz, the code is 0 for f ≤ 112000, 1 for f ≤ 125000, 2 for f ≤ 137000, 3 for f ≤ 150000, 4 for f ≤ 162000, 5 for f ≤ 175000, 6 for f ≤ 187000, 7 for f ≤ 200000, and 0 for any f above 200000.
- R5: Configuration bits other than 30, 29, 26:24, 18 and 16 keep their value through every sequence.
- R6: Once the output enable is set, the block samples lock_in on each edge. The first edge that sees it high ends the sequence, and done is high for that single following cycle.
- R7: If lock_in stays low for TIMEOUT_US × TICK_CYCLES edges after the output enable is set, lock_err pulses for one cycle and the block returns to idle. If lock is seen on that final edge, done wins.
- R8: A start pulse while busy is ignored: the write order does not restart, and no new sequence follows the current one.
- R9: busy is high from the cycle after start is accepted until the ending pulse. done and lock_err are never high together and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| clk_khz | input | KHZ_W | Current bus clock rate in kHz |
| lock_in | input | 1 | Lock flag from the delay loop |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: loop locked |
| lock_err | output | 1 | One-cycle pulse: lock timeout |
| vspec_q | output | REG_W | Vendor control register contents |
| dll_cfg_q | output | REG_W | DLL configuration register contents |

## Verification
The band encoder is driven with rates on both sides of every band edge: exactly 112000, 112001, 137000 and 137001, plus 200000, 200001 and a rate far above the range. These separate an off-by-one comparison from a missing top band that should fold back to code 0. Lock delays of zero, a few cycles, one less than the window, exactly the window, and never, show whether lock is sampled on the right edges and whether lock beats timeout on the last edge. A start pulsed in mid-write and again during the lock wait shows whether busy really locks out restarts. Consecutive sequences run on registers left set by earlier runs, so each bit write must be an edit of the current value.

// File: rtl/dllseq_pkg.sv
package dllseq_pkg;

   // Vendor register: clock gating permit
   localparam int PWRSAVE_BIT = 1;

   // DLL configuration register fields
   localparam int RST_BIT   = 30;
   localparam int PDN_BIT   = 29;
   localparam int CKOUT_BIT = 18;
   localparam int EN_BIT    = 16;
   localparam int BAND_LSB  = 24;
   localparam int BAND_W    = 3;
   localparam int N_BANDS   = 1 << BAND_W;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PWRSAVE,
      ST_RST_ON,
      ST_PDN_ON,
      ST_BAND,
      ST_RST_OFF,
      ST_PDN_OFF,
      ST_EN,
      ST_CKOUT,
      ST_LOCK
   } step_e;

   // Upper rate limit (kHz) of each band code
   function automatic logic [31:0] band_top_khz(input int idx);
      case (idx)
         0:       return 32'd112000;
         1:       return 32'd125000;
         2:       return 32'd137000;
         3:       return 32'd150000;
         4:       return 32'd162000;
         5:       return 32'd175000;
         6:       return 32'd187000;
         7:       return 32'd200000;
         default: return 32'd0;
      endcase
   endfunction

endpackage

// File: rtl/dllseq_band.sv
module dllseq_band
   import dllseq_pkg::*;
#(
   parameter int KHZ_W = 20
) (
   input  logic [KHZ_W-1:0]  clk_khz,
   output logic [BAND_W-1:0] band
);

   logic [N_BANDS-1:0] above;

   genvar g;
   generate
      for (g = 0; g < N_BANDS; g++) begin : g_cmp
         assign above[g] = 32'(clk_khz) > band_top_khz(g);
      end
   endgenerate

   // Count the band edges exceeded; above the top band folds to code 0
   always_comb begin
      band = '0;
      if (!above[N_BANDS-1]) begin
         for (int i = 0; i < N_BANDS - 1; i++) begin
            if (above[i]) band = band + BAND_W'(1);
         end
      end
   end

endmodule

// File: rtl/dllseq_wait.sv
module dllseq_wait #(
   parameter int TICK_CYCLES = 200,
   parameter int TIMEOUT_US  = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);

   logic tick;

   generate
      if (TICK_CYCLES == 1) begin : g_tick_direct
         assign tick = run;
      end else begin : g_tick_div
         localparam int CYC_W = $clog2(TICK_CYCLES);
         logic [CYC_W-1:0] cyc;
         assign tick = run && (cyc == CYC_W'(TICK_CYCLES - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cyc <= '0;
            else if (!run || tick) cyc <= '0;
            else                   cyc <= cyc + CYC_W'(1);
         end
      end

      if (TIMEOUT_US == 1) begin : g_us_direct
         assign expire = tick;
      end else begin : g_us_cnt
         localparam int US_W = $clog2(TIMEOUT_US);
         logic [US_W-1:0] us;
         assign expire = tick && (us == US_W'(TIMEOUT_US - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    us <= '0;
            else if (!run) us <= '0;
            else if (tick) us <= us + US_W'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
   import dllseq_pkg::*;
#(
   parameter int               KHZ_W       = 20,
   parameter int               TICK_CYCLES = 200,
   parameter int               TIMEOUT_US  = 50,
   parameter int               REG_W       = 32,
   parameter logic [REG_W-1:0] VSPEC_RST   = REG_W'(32'h0000_0003),
   parameter logic [REG_W-1:0] CFG_RST     = REG_W'(32'h0700_00A5)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [KHZ_W-1:0] clk_khz,
   input  logic             lock_in,
   output logic             busy,
   output logic             done,
   output logic             lock_err,
   output logic [REG_W-1:0] vspec_q,
   output logic [REG_W-1:0] dll_cfg_q
);

   generate
      if (REG_W < RST_BIT + 1) begin : g_bad_reg_w
         $error("REG_W too narrow for the configuration fields");
      end
      if (KHZ_W < 18 || KHZ_W > 32) begin : g_bad_khz_w
         $error("KHZ_W must be between 18 and 32");
      end
      if (TICK_CYCLES < 1) begin : g_bad_tick
         $error("TICK_CYCLES must be at least 1");
      end
      if (TIMEOUT_US < 1) begin : g_bad_timeout
         $error("TIMEOUT_US must be at least 1");
      end
   endgenerate

   step_e             st;
   logic [BAND_W-1:0] band;
   logic              expire;

   dllseq_band #(.KHZ_W(KHZ_W)) u_band (
      .clk_khz (clk_khz),
      .band    (band)
   );

   dllseq_wait #(
      .TICK_CYCLES (TICK_CYCLES),
      .TIMEOUT_US  (TIMEOUT_US)
   ) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (st == ST_LOCK),
      .expire (expire)
   );

   assign busy = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         vspec_q   <= VSPEC_RST;
         dll_cfg_q <= CFG_RST;
         done      <= 1'b0;
         lock_err  <= 1'b0;
      end else begin
         done     <= 1'b0;
         lock_err <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) st <= ST_PWRSAVE;
            end
            ST_PWRSAVE: begin
               vspec_q[PWRSAVE_BIT] <= 1'b0;
               st <= ST_RST_ON;
            end
            ST_RST_ON: begin
               dll_cfg_q[RST_BIT] <= 1'b1;
               st <= ST_PDN_ON;
            end
            ST_PDN_ON: begin
               dll_cfg_q[PDN_BIT] <= 1'b1;
               st <= ST_BAND;
            end
            ST_BAND: begin
               dll_cfg_q[BAND_LSB +: BAND_W] <= band;
               st <= ST_RST_OFF;
            end
            ST_RST_OFF: begin
               dll_cfg_q[RST_BIT] <= 1'b0;
               st <= ST_PDN_OFF;
            end
            ST_PDN_OFF: begin
               dll_cfg_q[PDN_BIT] <= 1'b0;
               st <= ST_EN;
            end
            ST_EN: begin
               dll_cfg_q[EN_BIT] <= 1'b1;
               st <= ST_CKOUT;
            end
            ST_CKOUT: begin
               dll_cfg_q[CKOUT_BIT] <= 1'b1;
               st <= ST_LOCK;
            end
            ST_LOCK: begin
               if (lock_in) begin
                  done <= 1'b1;
                  st   <= ST_IDLE;
               end else if (expire) begin
                  lock_err <= 1'b1;
                  st       <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dllseq_chk.sv
module dllseq_chk
   import dllseq_pkg::*;
#(
   parameter int REG_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             lock_in,
   input logic             busy,
   input logic             done,
   input logic             lock_err,
   input logic [REG_W-1:0] vspec_q,
   input logic [REG_W-1:0] dll_cfg_q
);

   localparam logic [REG_W-1:0] VSPEC_MASK = REG_W'(1) << PWRSAVE_BIT;
   localparam logic [REG_W-1:0] CFG_MASK =
      (REG_W'(1) << RST_BIT) | (REG_W'(1) << PDN_BIT) |
      (REG_W'(1) << CKOUT_BIT) | (REG_W'(1) << EN_BIT) |
      (REG_W'((1 << BAND_W) - 1) << BAND_LSB);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && lock_err)); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      lock_err |=> !lock_err); // R9

   AST_IDLE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy); // R9

   AST_VSPEC_ONLY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (((vspec_q ^ $past(vspec_q)) & ~VSPEC_MASK) == '0)); // R2

   AST_CFG_FIELDS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (((dll_cfg_q ^ $past(dll_cfg_q)) & ~CFG_MASK) == '0)); // R5

   AST_DONE_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && done) |-> $past(lock_in)); // R6

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(dll_cfg_q)); // R8

endmodule

bind dll_bringup_seq dllseq_chk #(.REG_W(REG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .lock_in   (lock_in),
   .busy      (busy),
   .done      (done),
   .lock_err  (lock_err),
   .vspec_q   (vspec_q),
   .dll_cfg_q (dll_cfg_q)
);

// File: tb/dll_bringup_seq_bench.sv
`timescale 1ns/1ps
module dll_bringup_seq_bench;

   localparam int          KHZ_W = 20;
   localparam int          TICK  = 4;
   localparam int          TOUT  = 50;
   localparam int          WIN   = TICK * TOUT;
   localparam logic [31:0] VS0   = 32'h0000_0F03;
   localparam logic [31:0] CF0   = 32'h0500_00A5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [KHZ_W-1:0] clk_khz = '0;
   logic             lock_in = 1'b0;
   logic             busy, done, lock_err;
   logic [31:0]      vspec_q, dll_cfg_q;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [31:0] vs_exp = VS0;
   logic [31:0] cf_exp = CF0;

   always #2.5 clk = ~clk;

   dll_bringup_seq #(
      .KHZ_W(KHZ_W), .TICK_CYCLES(TICK), .TIMEOUT_US(TOUT), .REG_W(32),
      .VSPEC_RST(VS0), .CFG_RST(CF0)
   ) u_dll_bringup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .clk_khz(clk_khz),
      .lock_in(lock_in), .busy(busy), .done(done), .lock_err(lock_err),
      .vspec_q(vspec_q), .dll_cfg_q(dll_cfg_q)
   );

   // rate in kHz, lock delay in cycles after the output enable write
   localparam int VEC [14][2] = '{
      '{ 50000, 0}, '{112000, 3}, '{112001, 1}, '{125000, 2},
      '{137000, 0}, '{137001, 5}, '{150000, 1}, '{162000, 0},
      '{170000, 7}, '{187000, 2}, '{187001, 0}, '{200000, 4},
      '{200001, 0}, '{400000, 0}
   };

   function automatic logic [2:0] exp_band(input int f);
      if (f > 200000)      return 3'd0;
      else if (f > 187000) return 3'd7;
      else if (f > 175000) return 3'd6;
      else if (f > 162000) return 3'd5;
      else if (f > 150000) return 3'd4;
      else if (f > 137000) return 3'd3;
      else if (f > 125000) return 3'd2;
      else if (f > 112000) return 3'd1;
      else                 return 3'd0;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_case(input int khz, input int lim, input bit poke);
      logic [2:0] code;
      int k;
      bit got;
      bit exp_done;
      int exp_k;
      code = exp_band(khz);
      clk_khz = KHZ_W'(khz);
      lock_in = 1'b0;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      for (int s = 1; s <= 8; s++) begin
         start = poke && (s == 3);
         @(posedge clk); #1;
         case (s)
            1: vs_exp[1] = 1'b0;
            2: cf_exp[30] = 1'b1;
            3: cf_exp[29] = 1'b1;
            4: cf_exp[26:24] = code;
            5: cf_exp[30] = 1'b0;
            6: cf_exp[29] = 1'b0;
            7: cf_exp[16] = 1'b1;
            default: cf_exp[18] = 1'b1;
         endcase
         chk(vspec_q == vs_exp, "R2", "vendor reg", 64'(vspec_q), 64'(vs_exp));
         if (s == 4)
            chk(dll_cfg_q == cf_exp, "R4", "band code write", 64'(dll_cfg_q), 64'(cf_exp));
         else
            chk(dll_cfg_q == cf_exp, "R3", "cfg write order", 64'(dll_cfg_q), 64'(cf_exp));
         chk(busy == 1'b1, "R9", "busy during writes", 64'(busy), 64'(1));
      end
      start = 1'b0;
      k = 0;
      got = 1'b0;
      while (!got && k < WIN + 5) begin
         if (k == lim) lock_in = 1'b1;
         start = poke && (k == 2);
         @(posedge clk); #1;
         k++;
         if (done || lock_err) got = 1'b1;
      end
      start = 1'b0;
      exp_done = (lim <= WIN - 1);
      exp_k = exp_done ? lim + 1 : WIN;
      if (exp_done) begin
         chk(done == 1'b1 && lock_err == 1'b0, "R6", "done on lock", 64'({done, lock_err}), 64'(2'b10));
         chk(k == exp_k, "R6", "done cycle", 64'(k), 64'(exp_k));
      end else begin
         chk(lock_err == 1'b1 && done == 1'b0, "R7", "timeout pulse", 64'({done, lock_err}), 64'(2'b01));
         chk(k == exp_k, "R7", "timeout cycle", 64'(k), 64'(exp_k));
      end
      chk(dll_cfg_q == cf_exp, "R5", "cfg after sequence", 64'(dll_cfg_q), 64'(cf_exp));
      @(posedge clk); #1;
      chk(done == 1'b0 && lock_err == 1'b0 && busy == 1'b0, "R9", "pulse ends, idle",
          64'({done, lock_err, busy}), 64'(0));
      lock_in = 1'b0;
      if (poke) begin
         for (int j = 0; j < 3; j++) begin
            @(posedge clk); #1;
            chk(busy == 1'b0 && dll_cfg_q == cf_exp, "R8", "no restart after ignored start",
                {31'(0), busy, dll_cfg_q}, {31'(0), 1'b0, cf_exp});
         end
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(vspec_q == VS0 && dll_cfg_q == CF0, "R1", "regs in reset",
          {vspec_q, dll_cfg_q}, {VS0, CF0});
      chk(busy == 1'b0 && done == 1'b0 && lock_err == 1'b0, "R1", "flags in reset",
          64'({busy, done, lock_err}), 64'(0));
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(vspec_q == VS0 && dll_cfg_q == CF0 && !busy, "R1", "state after release",
          {vspec_q, dll_cfg_q}, {VS0, CF0});

      for (int i = 0; i < 14; i++) run_case(VEC[i][0], VEC[i][1], 1'b0);

      run_case(180000, WIN - 1, 1'b0); // R7: lock on last edge wins
      run_case(120000, WIN, 1'b0);     // R7: lock one edge too late
      run_case(90000, 100000, 1'b0);   // R7: lock never arrives
      run_case(160000, 10, 1'b1);      // R8: start pulsed while busy

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule